// File: doc/BRIEF.md
# Status LED Multiplexer

This block drives a bank of eight user LEDs on a carrier board. In local mode the LEDs show board status: the state of the adjustable I/O supply and how its voltage is chosen, whether register control is in effect, stretched UART activity on the module side and on the host-bridge side, the boot source, one boot-mode strap and two auxiliary board signals. When a remote GPIO link reports itself active, seven of the eight LEDs show the bits that the remote side sends instead. The serial protocol of that link is handled elsewhere; this block only sees its active flag and the received bits.

The first LED is a three-way supply indicator. While the adjustable supply is switched off it blinks at about 2 Hz. With the supply on it is lit when the voltage is chosen by the legacy selector or by register control, and dark when the DIP selector chooses it. A prescaler and a two-state machine (`BL_DARK`, `BL_LIT`, changing state on each prescaler tick) produce the blink. Each UART activity strobe passes through a retriggerable stretcher with two states: `ST_IDLE` moves to `ST_HOLD` on a strobe. `ST_HOLD` reloads its counter on every new strobe and returns to `ST_IDLE` once the counter has run out. In the output stage the supply indicator uses three named modes, `L1_BLINK`, `L1_SOLID` and `L1_DARK`. All LED outputs are registered.

Top module: `status_led_mux`

## Requirements
- R1: While `rst_n` is low, all eight `led` bits are 0, whatever the inputs are.
- R2: While `vio_en` is 0, `led[0]` blinks with a period of 2*`BLINK_HALF_CYCLES` clocks at 50 % duty, lit and dark for `BLINK_HALF_CYCLES` clocks each.
- R3: While `vio_en` is 1 and `vsel_dip` is 0, `led[0]` is 1 one clock after those input values are sampled.
- R4: While `vio_en` is 1 and `vsel_dip` is 1, `led[0]` is 0 one clock after those input values are sampled.
- R5: While `rbus_active` is 0, one clock later `led[1]`=`reg_mode`, `led[4]`=`boot_flash` (1 for flash boot, 0 for SD boot), `led[5]`=`mode_strap2`, `led[6]`=`probe_x` and `led[7]`=`probe_y`.
- R6: While `rbus_active` is 0, a single-cycle strobe on `uart_mod_act` (or `uart_host_act`) sampled at edge E sets `led[2]` (or `led[3]`) to 1 after edges E+1 through E+`STRETCH_CYCLES`, and to 0 after the next edge.
- R7: A new strobe during the stretch restarts it: the LED stays lit until `STRETCH_CYCLES` clocks after the last strobe.
- R8: While `rbus_active` is 1, one clock later `led[k]`=`rbus_pins[k]` for k = 1..7. The local status and activity inputs then have no effect on `led[7:1]`.
- R9: `led[0]` follows R2 to R4 whatever the state of `rbus_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vio_en | input | 1 | 1 when the adjustable I/O supply is enabled |
| vsel_dip | input | 1 | 1 when the DIP selector sets the supply voltage, 0 when the legacy selector or register control sets it |
| reg_mode | input | 1 | 1 when register control of the supply is active |
| uart_mod_act | input | 1 | Single-cycle activity strobe, module-side UART |
| uart_host_act | input | 1 | Single-cycle activity strobe, host-bridge UART |
| boot_flash | input | 1 | 1 for flash boot, 0 for SD boot |
| mode_strap2 | input | 1 | Third boot-mode strap level |
| probe_x | input | 1 | Auxiliary board signal X |
| probe_y | input | 1 | Auxiliary board signal Y |
| rbus_active | input | 1 | 1 while the remote GPIO link is running |
| rbus_pins | input | 7 | Remote bits 7..1, bit k drives `led[k]` |
| led | output | 8 | LED levels, bit 0 is the supply indicator |

## Verification
A vector table covers the static mapping. Each row changes several local inputs at once and uses remote bit patterns that differ from the local levels, so a swapped LED, a wrong bit order or a missing switch to remote mode all show up as a mismatch. Every row also pairs one of the two solid supply-indicator cases with either mode. Directed cases send one strobe into each stretcher and watch the exact lit window. A second strobe in the middle shows that the stretcher restarts and does not just run to its end. A strobe with the link active shows that local activity is ignored. The blink is measured over whole periods with the link active, counting lit cycles and transitions, so both the duty cycle and the independence from the remote link are checked.

// File: rtl/sled_pkg.sv
package sled_pkg;

    localparam int NUM_LEDS = 8;
    localparam int NUM_ACT  = 2;

    typedef enum logic {
        BL_DARK,
        BL_LIT
    } blink_state_t;

    typedef enum logic {
        ST_IDLE,
        ST_HOLD
    } stretch_state_t;

    typedef enum logic [1:0] {
        L1_BLINK,
        L1_SOLID,
        L1_DARK
    } led1_mode_t;

    function automatic led1_mode_t pick_led1_mode(input logic supply_on,
                                                  input logic dip_ctl);
        led1_mode_t m;
        if (!supply_on)
            m = L1_BLINK;
        else if (dip_ctl)
            m = L1_DARK;
        else
            m = L1_SOLID;
        return m;
    endfunction

endpackage

// File: rtl/sled_blinker.sv
module sled_blinker
    import sled_pkg::*;
#(
    parameter int unsigned HALF_CYCLES = 62_500_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic blink
);

    localparam int unsigned CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

    logic [CW-1:0] div_q;
    logic          tick;
    blink_state_t  st_q;
    blink_state_t  st_d;

    assign tick = (div_q == LAST);

    // prescaler
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (tick)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= BL_DARK;
        else
            st_q <= st_d;
    end

    // next state
    always_comb begin
        unique case (st_q)
            BL_DARK: st_d = tick ? BL_LIT  : BL_DARK;
            BL_LIT:  st_d = tick ? BL_DARK : BL_LIT;
            default: st_d = BL_DARK;
        endcase
    end

    // outputs
    always_comb begin
        blink = (st_q == BL_LIT);
    end

endmodule

// File: rtl/sled_stretch.sv
module sled_stretch
    import sled_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 12_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic active
);

    localparam int unsigned CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYCLES - 1);

    stretch_state_t st_q;
    stretch_state_t st_d;
    logic [CW-1:0]  cnt_q;
    logic [CW-1:0]  cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // transitions: IDLE->HOLD on strobe, HOLD reload on strobe, HOLD->IDLE on expiry
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (strobe) begin
                    st_d  = ST_HOLD;
                    cnt_d = RELOAD;
                end
            end
            ST_HOLD: begin
                if (strobe) begin
                    cnt_d = RELOAD;
                end else if (cnt_q == '0) begin
                    st_d  = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                st_d  = ST_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        active = (st_q == ST_HOLD);
    end

endmodule

// File: rtl/sled_drive.sv
module sled_drive
    import sled_pkg::*;
#(
    parameter int LEDS = NUM_LEDS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            blink,
    input  logic            supply_on,
    input  logic            dip_ctl,
    input  logic            reg_mode,
    input  logic            act_mod,
    input  logic            act_host,
    input  logic            boot_flash,
    input  logic            strap2,
    input  logic            px,
    input  logic            py,
    input  logic            bus_on,
    input  logic [LEDS-1:1] bus_bits,
    output logic [LEDS-1:0] led
);

    led1_mode_t      mode;
    logic            ind_d;
    logic [LEDS-1:1] local_d;
    logic [LEDS-1:1] upper_d;
    logic [LEDS-1:0] led_q;

    assign mode = pick_led1_mode(supply_on, dip_ctl);

    // supply indicator
    always_comb begin
        unique case (mode)
            L1_BLINK: ind_d = blink;
            L1_SOLID: ind_d = 1'b1;
            L1_DARK:  ind_d = 1'b0;
            default:  ind_d = 1'b0;
        endcase
    end

    // local status arrangement, LED2..LED8
    always_comb begin
        local_d    = '0;
        local_d[1] = reg_mode;
        local_d[2] = act_mod;
        local_d[3] = act_host;
        local_d[4] = boot_flash;
        local_d[5] = strap2;
        local_d[6] = px;
        local_d[7] = py;
    end

    always_comb begin
        upper_d = bus_on ? bus_bits : local_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            led_q <= '0;
        else
            led_q <= {upper_d, ind_d};
    end

    always_comb begin
        led = led_q;
    end

endmodule

// File: rtl/status_led_mux.sv
module status_led_mux
    import sled_pkg::*;
#(
    parameter int unsigned BLINK_HALF_CYCLES = 62_500_000,
    parameter int unsigned STRETCH_CYCLES    = 12_500_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vio_en,
    input  logic       vsel_dip,
    input  logic       reg_mode,
    input  logic       uart_mod_act,
    input  logic       uart_host_act,
    input  logic       boot_flash,
    input  logic       mode_strap2,
    input  logic       probe_x,
    input  logic       probe_y,
    input  logic       rbus_active,
    input  logic [7:1] rbus_pins,
    output logic [7:0] led
);

    logic               blink;
    logic [NUM_ACT-1:0] strobes;
    logic [NUM_ACT-1:0] act;

    assign strobes = {uart_host_act, uart_mod_act};

    sled_blinker #(
        .HALF_CYCLES(BLINK_HALF_CYCLES)
    ) u_blink (
        .clk   (clk),
        .rst_n (rst_n),
        .blink (blink)
    );

    for (genvar g = 0; g < NUM_ACT; g++) begin : g_act
        sled_stretch #(
            .HOLD_CYCLES(STRETCH_CYCLES)
        ) u_st (
            .clk    (clk),
            .rst_n  (rst_n),
            .strobe (strobes[g]),
            .active (act[g])
        );
    end

    sled_drive #(
        .LEDS(NUM_LEDS)
    ) u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .blink      (blink),
        .supply_on  (vio_en),
        .dip_ctl    (vsel_dip),
        .reg_mode   (reg_mode),
        .act_mod    (act[0]),
        .act_host   (act[1]),
        .boot_flash (boot_flash),
        .strap2     (mode_strap2),
        .px         (probe_x),
        .py         (probe_y),
        .bus_on     (rbus_active),
        .bus_bits   (rbus_pins),
        .led        (led)
    );

endmodule

// File: rtl/sled_checks.sv
module sled_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       vio_en,
    input logic       vsel_dip,
    input logic       reg_mode,
    input logic       uart_mod_act,
    input logic       uart_host_act,
    input logic       boot_flash,
    input logic       mode_strap2,
    input logic       probe_x,
    input logic       probe_y,
    input logic       rbus_active,
    input logic [7:1] rbus_pins,
    input logic [7:0] led
);

    logic warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            warm <= 1'b0;
        else
            warm <= 1'b1;
    end

    // R1: dark during reset
    always @(posedge clk) begin
        if (!rst_n)
            a_r1_dark_in_reset: assert (led == 8'h00);
    end

    a_r3_solid_indicator: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        ($past(vio_en) && !$past(vsel_dip)) |-> led[0]);

    a_r4_dip_dark: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        ($past(vio_en) && $past(vsel_dip)) |-> !led[0]);

    a_r5_local_map: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        !$past(rbus_active) |->
            (led[1] == $past(reg_mode)) && (led[4] == $past(boot_flash)) &&
            (led[5] == $past(mode_strap2)) && (led[6] == $past(probe_x)) &&
            (led[7] == $past(probe_y)));

    a_r6_strobe_shows: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        ($past(uart_mod_act, 2) && !$past(rbus_active)) |-> led[2]);

    a_r8_remote_map: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        $past(rbus_active) |-> (led[7:1] == $past(rbus_pins)));

endmodule

bind status_led_mux sled_checks u_chk (.*);

// File: tb/status_led_mux_test.sv
`timescale 1ns/1ps
module status_led_mux_test;

    localparam int HALF = 8;
    localparam int STR  = 20;
    localparam int NV   = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vio_en = 1'b0, vsel_dip = 1'b0, reg_mode = 1'b0;
    logic       uart_mod_act = 1'b0, uart_host_act = 1'b0;
    logic       boot_flash = 1'b0, mode_strap2 = 1'b0, probe_x = 1'b0, probe_y = 1'b0;
    logic       rbus_active = 1'b0;
    logic [7:1] rbus_pins = '0;
    logic [7:0] led;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    status_led_mux #(
        .BLINK_HALF_CYCLES(HALF),
        .STRETCH_CYCLES(STR)
    ) uut (
        .clk(clk), .rst_n(rst_n), .vio_en(vio_en), .vsel_dip(vsel_dip),
        .reg_mode(reg_mode), .uart_mod_act(uart_mod_act), .uart_host_act(uart_host_act),
        .boot_flash(boot_flash), .mode_strap2(mode_strap2), .probe_x(probe_x),
        .probe_y(probe_y), .rbus_active(rbus_active), .rbus_pins(rbus_pins), .led(led)
    );

    // {vio, dip, reg, boot, strap2, px, py, act, rb[7:1], expected led}
    localparam logic [22:0] VEC [NV] = '{
        {1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,7'b0000000,8'b0000_0001},
        {1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,7'b0000000,8'b0000_0010},
        {1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,7'b0000000,8'b1011_0001},
        {1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,7'b1111111,8'b1111_0010},
        {1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,7'b0000000,8'b0000_0001},
        {1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,7'b1010101,8'b1010_1010},
        {1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,7'b0110011,8'b0110_0111},
        {1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,7'b1111111,8'b1111_1110}
    };

    task automatic check(input bit ok, input string req, input int act_v, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // strobe a stretcher and compare the lit window; second strobe optional
    task automatic stretch_run(input int which, input int gap, input string req);
        int bad = 0;
        int last = 1;
        int bit_i = (which == 0) ? 2 : 3;
        @(negedge clk);
        if (which == 0) uart_mod_act = 1'b1; else uart_host_act = 1'b1;
        for (int n = 1; n <= gap + STR + 3; n++) begin
            @(negedge clk);
            uart_mod_act  = 1'b0;
            uart_host_act = 1'b0;
            if (gap > 0 && n == gap) begin
                if (which == 0) uart_mod_act = 1'b1; else uart_host_act = 1'b1;
                last = gap + 1;
            end
            if (led[bit_i] !== ((n >= 2 && n <= last + STR) ? 1'b1 : 1'b0)) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int highs, changes;
        logic prev;
        // R1: reset holds LEDs dark with lit-worthy inputs applied
        vio_en = 1'b1; reg_mode = 1'b1; rbus_active = 1'b1; rbus_pins = 7'h7F;
        repeat (4) @(negedge clk);
        check(led == 8'h00, "R1", led, 0);
        rst_n = 1'b1;

        // R3 R4 R5 R8: vector table
        for (int i = 0; i < NV; i++) begin
            vio_en      = VEC[i][22];
            vsel_dip    = VEC[i][21];
            reg_mode    = VEC[i][20];
            boot_flash  = VEC[i][19];
            mode_strap2 = VEC[i][18];
            probe_x     = VEC[i][17];
            probe_y     = VEC[i][16];
            rbus_active = VEC[i][15];
            rbus_pins   = VEC[i][14:8];
            @(negedge clk);
            check(led == VEC[i][7:0], "R3/R4/R5/R8 vector", led, VEC[i][7:0]);
        end

        // R6 R7: stretchers with bus inactive
        vio_en = 1'b1; vsel_dip = 1'b0; reg_mode = 1'b0; boot_flash = 1'b0;
        mode_strap2 = 1'b0; probe_x = 1'b0; probe_y = 1'b0;
        rbus_active = 1'b0; rbus_pins = '0;
        repeat (STR + 4) @(negedge clk);
        stretch_run(0, 0, "R6 module strobe");
        stretch_run(1, 0, "R6 host strobe");
        stretch_run(1, 10, "R7 retrigger");

        // R8: local inputs ignored while bus active
        rbus_active = 1'b1; rbus_pins = 7'b0000000; reg_mode = 1'b1; boot_flash = 1'b1;
        @(negedge clk);
        uart_mod_act = 1'b1;
        highs = 0;
        for (int n = 0; n < STR; n++) begin
            @(negedge clk);
            uart_mod_act = 1'b0;
            if (led[7:1] != 7'b0) highs++;
        end
        check(highs == 0, "R8 local ignored", highs, 0);

        // R2 R9: blink with supply off, bus active
        vio_en = 1'b0;
        repeat (3) @(negedge clk);
        highs = 0; changes = 0; prev = led[0];
        for (int n = 0; n < 4 * HALF; n++) begin
            @(negedge clk);
            if (led[0]) highs++;
            if (led[0] != prev) changes++;
            prev = led[0];
        end
        check(highs == 2 * HALF, "R2/R9 duty", highs, 2 * HALF);
        check(changes >= 3 && changes <= 4, "R2 transitions", changes, 4);

        finish_run();
    end

endmodule